// File: doc/BRIEF.md
# ATAPI Packet Result and Sense Engine

This block sits behind the task-file register front end of an optical-drive device model. Once the host has finished writing a 12-byte command packet, the block takes the whole packet in one cycle and decodes its opcode. It then produces the outcome: it updates the sense bytes, the error register and the status register, raises the interrupt line, and tells the transfer machine which data phase to open (none, device-to-host or host-to-device) and how many bytes it carries.

Commands that return a slice of an internal area (the mode area, the drive-state area or the sense bytes) take a byte offset and a byte count from the packet. The offset is checked against the size of the area, and the count is cut down so the slice stays inside it. A sector read loads a start address, a sector count and a read mode. It then runs one media request per sector through a ready/result handshake. The address moves forward and the count drops after every sector that arrives. The first address that fails is recorded in the sense bytes. A mode-select data-out phase writes host bytes back into the writable head of the mode area. The host reads bytes of the open window through a combinational index port.

Top module: `atapi_pkt_result`

## Requirements
- R1: After reset, status is 0x50, error is 0x00, the interrupt is low, no data phase is open, no media request is pending and every sense byte reads 0x00. Status bits: 0x80 busy, 0x40 ready, 0x10 seek done, 0x08 data request, 0x01 check.
- R2: Reporting a 16-bit result code writes 0xF0 to sense byte 0, the code's low byte to sense byte 2 and its high byte to sense byte 8. The sense command (opcode 0x13) returns the stored sense bytes without changing them. Its byte count (packet byte 4) is clamped to 10.
- R3: Each reported result loads the error register with bits 3:0 of the code placed in bits 7:4, with zeros below. A success therefore gives 0x00.
- R4: A failing result sets status to 0x51, closes any phase, returns to idle and raises the interrupt. A success clears only the busy and check bits of the current status. The interrupt is cleared by the acknowledge input or by the next accepted packet.
- R5: A unit-reset flag is set by reset. The first packet with an opcode other than 0x13 is answered with result 0x2906 and clears the flag. Sense packets leave the flag set. The ready test (opcode 0x00) then succeeds with no data phase.
- R6: A sector read (opcode 0x30) takes the start address from packet bytes 2..4 (most significant first), the sector count from bytes 8..10 and the read mode from byte 1. With a nonzero count, status becomes busy and a media request is raised with that address and mode. A zero count succeeds at once.
- R7: Each sector delivered successfully opens a device-to-host phase of the reported sector size and moves the address up by one. It also lowers the remaining count by one. When a phase completes with sectors remaining, the block goes busy and requests the next sector; with none left, it returns to status 0x50 and raises the interrupt.
- R8: A failed sector reports the media's result code, puts the failing address in sense bytes 5..7 (most significant first) and leaves the address and the remaining count unchanged.
- R9: Window reads of the mode area (opcode 0x11, 32 bytes) and of the drive-state area (opcode 0x10, 10 bytes) take the offset from packet byte 2 and the count from byte 4. An offset at or past the area's size gives result 0x2405. Otherwise the count becomes min(count, size − offset). The drive-state area holds the address (bytes 0..2, MSB first), the read mode (byte 3), the remaining count (bytes 4..6, MSB first) and zeros.
- R10: Mode byte i resets to {i[3:0], ~i[3:0]}. Mode select (opcode 0x12, same offset, count and offset check) opens a host-to-device phase. Host byte k lands at mode byte offset+k only while that index is below 10. Host writes outside that phase have no effect.
- R11: Any other opcode gives result 0x2005.
- R12: Opening a phase pulses the phase-start output for one cycle, sets the data-request bit, drives the byte count and the direction (1 = to host, 2 = from host) and raises the interrupt. Completing a window phase clears the data-request bit, returns to 0x50 and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Complete packet present (accepted when idle) |
| pktData | input | 96 | Packet, byte n at bits 8n+7:8n |
| hostIdx | input | 8 | Byte index within the open window |
| hostWrEn | input | 1 | Host writes one byte at hostIdx |
| hostWrByte | input | 8 | Byte written by the host |
| hostRdByte | output | 8 | Window byte at hostIdx |
| xferDone | input | 1 | Transfer machine finished the open phase |
| irqAck | input | 1 | Host acknowledge, clears the interrupt |
| sectorReq | output | 1 | Media request pending |
| sectorLba | output | 24 | Current sector address |
| sectorMode | output | 8 | Current read mode |
| sectorDone | input | 1 | Media answers the request |
| sectorOk | input | 1 | Media answer is a success |
| sectorErr | input | 16 | Media result code on failure |
| sectorBytes | input | 16 | Size of the delivered sector |
| statusReg | output | 8 | Status register |
| errorReg | output | 8 | Error register |
| irq | output | 1 | Interrupt request |
| phaseStart | output | 1 | One-cycle pulse when a phase opens |
| phaseKind | output | 2 | 0 none, 1 to host, 2 from host |
| xferLen | output | 16 | Byte count of the phase |

## Verification
The hardest state to reach is a failure on a later sector of a multi-sector read. The bench must let one sector through, complete its phase and then answer the next request with an error, before it can show that the sense address is the failing sector's and not the start address. The unit-reset flag can also only be observed in the window right after reset. So the bench's first packet is a sense request, to prove that the flag survives one, and only then sends a ready test. Mode-select clipping is checked by writing across the writable limit and reading the area back through a mode-sense window.

// File: rtl/atapi_result_pkg.sv
package atapi_result_pkg;
  localparam int SENSE_LEN = 10;
  localparam int STAT_LEN  = 10;

  localparam logic [7:0] OP_TEST_READY  = 8'h00;
  localparam logic [7:0] OP_STAT_READ   = 8'h10;
  localparam logic [7:0] OP_MODE_SENSE  = 8'h11;
  localparam logic [7:0] OP_MODE_SELECT = 8'h12;
  localparam logic [7:0] OP_SENSE       = 8'h13;
  localparam logic [7:0] OP_SECTOR_READ = 8'h30;

  localparam logic [15:0] RES_OK       = 16'h0000;
  localparam logic [15:0] RES_RESET    = 16'h2906;
  localparam logic [15:0] RES_BADCMD   = 16'h2005;
  localparam logic [15:0] RES_BADFIELD = 16'h2405;

  localparam logic [7:0] ST_BSY_BIT  = 8'h80;
  localparam logic [7:0] ST_DRQ_BIT  = 8'h08;
  localparam logic [7:0] ST_CHK_BIT  = 8'h01;
  localparam logic [7:0] ST_READY    = 8'h50;
  localparam logic [7:0] ST_FAILED   = 8'h51;

  typedef enum logic [1:0] {PH_NONE = 2'd0, PH_IN = 2'd1, PH_OUT = 2'd2} phase_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_MODE, SRC_STAT, SRC_SENSE} src_e;
  typedef enum logic [2:0] {SO_KEEP, SO_FAIL, SO_OK, SO_OK_DRQ, SO_BUSY, SO_DONE} statOp_e;

  typedef struct packed {
    logic        report;
    logic [15:0] code;
    logic        failLba;
    statOp_e     statOp;
    logic        irqSet;
    logic        irqClr;
    logic        loadSector;
    logic [23:0] lba;
    logic [23:0] count;
    logic [7:0]  mode;
    logic        advance;
    logic        phaseGo;
    phase_e      phase;
    logic [15:0] len;
    logic [7:0]  winOff;
    src_e        src;
    logic        modeWrEn;
    logic        clrResetFlag;
    logic        setLastOp;
    logic [7:0]  lastOp;
  } ctrlStrobe_t;

  function automatic logic [7:0] defaultModeByte(input int idx);
    logic [7:0] b;
    b = 8'(idx);
    return {b[3:0], ~b[3:0]};
  endfunction
endpackage

// File: rtl/atapi_pkt_ctrl.sv
module atapi_pkt_ctrl
  import atapi_result_pkg::*;
#(
  parameter int MODE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic [95:0] pktData,
  input  logic        xferDone,
  input  logic        hostWrEn,
  input  logic        sectorDone,
  input  logic        sectorOk,
  input  logic [15:0] sectorErr,
  input  logic [15:0] sectorBytes,
  input  logic        resetFlag,
  input  logic [23:0] remain,
  input  logic [7:0]  lastOp,
  output ctrlStrobe_t stb,
  output logic        sectorReq
);
  localparam logic [8:0] MODE_LEN9  = 9'(MODE_LEN);
  localparam logic [8:0] STAT_LEN9  = 9'(STAT_LEN);
  localparam logic [8:0] SENSE_LEN9 = 9'(SENSE_LEN);

  typedef enum logic [2:0] {S_IDLE, S_SEC_WAIT, S_SEC_XFER, S_IN_XFER, S_OUT_XFER} state_e;
  state_e state, nextState;

  logic [7:0] op, offRaw, lenRaw;
  logic [8:0] areaLen, effOff, winEnd, clampLen;
  logic       offBad;
  logic [23:0] pktLba, pktCount;
  logic unusedPktBits;

  assign op       = pktData[7:0];
  assign offRaw   = pktData[23:16];
  assign lenRaw   = pktData[39:32];
  assign pktLba   = {pktData[23:16], pktData[31:24], pktData[39:32]};
  assign pktCount = {pktData[71:64], pktData[79:72], pktData[87:80]};
  assign unusedPktBits = ^{pktData[95:88], pktData[63:40]};

  always_comb begin
    unique case (op)
      OP_MODE_SENSE, OP_MODE_SELECT: areaLen = MODE_LEN9;
      OP_STAT_READ:                  areaLen = STAT_LEN9;
      default:                       areaLen = SENSE_LEN9;
    endcase
    effOff   = (op == OP_SENSE) ? 9'd0 : {1'b0, offRaw};
    winEnd   = effOff + {1'b0, lenRaw};
    offBad   = effOff >= areaLen;
    clampLen = (winEnd > areaLen) ? (areaLen - effOff) : {1'b0, lenRaw};
  end

  assign sectorReq = (state == S_SEC_WAIT);

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (pktValid) begin
        stb.irqClr = 1'b1;
        if (resetFlag && op != OP_SENSE) begin
          stb.report       = 1'b1;
          stb.code         = RES_RESET;
          stb.statOp       = SO_FAIL;
          stb.irqSet       = 1'b1;
          stb.clrResetFlag = 1'b1;
        end else begin
          stb.setLastOp = 1'b1;
          stb.lastOp    = op;
          unique case (op)
            OP_TEST_READY: begin
              stb.report = 1'b1;
              stb.code   = RES_OK;
              stb.statOp = SO_OK;
              stb.irqSet = 1'b1;
            end
            OP_SENSE, OP_MODE_SENSE, OP_STAT_READ, OP_MODE_SELECT: begin
              stb.irqSet = 1'b1;
              if (offBad) begin
                stb.report = 1'b1;
                stb.code   = RES_BADFIELD;
                stb.statOp = SO_FAIL;
              end else begin
                stb.report  = (op != OP_SENSE);
                stb.code    = RES_OK;
                stb.statOp  = SO_OK_DRQ;
                stb.phaseGo = 1'b1;
                stb.phase   = (op == OP_MODE_SELECT) ? PH_OUT : PH_IN;
                stb.len     = {7'd0, clampLen};
                stb.winOff  = effOff[7:0];
                stb.src     = (op == OP_STAT_READ) ? SRC_STAT :
                              (op == OP_SENSE) ? SRC_SENSE : SRC_MODE;
                nextState   = (op == OP_MODE_SELECT) ? S_OUT_XFER : S_IN_XFER;
              end
            end
            OP_SECTOR_READ: begin
              stb.loadSector = 1'b1;
              stb.lba        = pktLba;
              stb.count      = pktCount;
              stb.mode       = pktData[15:8];
              if (pktCount == 24'd0) begin
                stb.report = 1'b1;
                stb.code   = RES_OK;
                stb.statOp = SO_OK;
                stb.irqSet = 1'b1;
              end else begin
                stb.statOp = SO_BUSY;
                nextState  = S_SEC_WAIT;
              end
            end
            default: begin
              stb.report = 1'b1;
              stb.code   = RES_BADCMD;
              stb.statOp = SO_FAIL;
              stb.irqSet = 1'b1;
            end
          endcase
        end
      end
      S_SEC_WAIT: if (sectorDone) begin
        stb.report = 1'b1;
        stb.irqSet = 1'b1;
        if (sectorOk) begin
          stb.code    = RES_OK;
          stb.advance = 1'b1;
          stb.statOp  = SO_OK_DRQ;
          stb.phaseGo = 1'b1;
          stb.phase   = PH_IN;
          stb.len     = sectorBytes;
          stb.src     = SRC_NONE;
          nextState   = S_SEC_XFER;
        end else begin
          stb.code    = sectorErr;
          stb.failLba = 1'b1;
          stb.statOp  = SO_FAIL;
          nextState   = S_IDLE;
        end
      end
      S_SEC_XFER: if (xferDone) begin
        if (remain == 24'd0) begin
          stb.statOp = SO_DONE;
          stb.irqSet = 1'b1;
          nextState  = S_IDLE;
        end else begin
          stb.statOp = SO_BUSY;
          nextState  = S_SEC_WAIT;
        end
      end
      S_IN_XFER: if (xferDone) begin
        stb.statOp = SO_DONE;
        stb.irqSet = 1'b1;
        nextState  = S_IDLE;
      end
      S_OUT_XFER: begin
        stb.modeWrEn = hostWrEn && (lastOp == OP_MODE_SELECT);
        if (xferDone) begin
          stb.statOp = SO_DONE;
          stb.irqSet = 1'b1;
          nextState  = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/atapi_pkt_datapath.sv
module atapi_pkt_datapath
  import atapi_result_pkg::*;
#(
  parameter int MODE_LEN = 32,
  parameter int WR_LEN   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  input  logic        irqAck,
  input  logic [7:0]  hostIdx,
  input  logic [7:0]  hostWrByte,
  output logic [7:0]  hostRdByte,
  output logic [23:0] lbaQ,
  output logic [7:0]  modeQ,
  output logic [23:0] remainQ,
  output logic [7:0]  lastOpQ,
  output logic        resetFlagQ,
  output logic [7:0]  statusQ,
  output logic [7:0]  errorQ,
  output logic        irqQ,
  output logic        phaseStartQ,
  output logic [1:0]  phaseKindQ,
  output logic [15:0] xferLenQ
);
  logic [7:0] sense [SENSE_LEN];
  logic [7:0] modeW [WR_LEN];
  logic [7:0] winOffQ;
  src_e       srcQ;
  logic [8:0] idxAddr;

  assign idxAddr = {1'b0, winOffQ} + {1'b0, hostIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SENSE_LEN; i++) sense[i] <= 8'h00;
    end else begin
      if (stb.report) begin
        sense[0] <= 8'hF0;
        sense[2] <= stb.code[7:0];
        sense[8] <= stb.code[15:8];
      end
      if (stb.failLba) begin
        sense[5] <= lbaQ[23:16];
        sense[6] <= lbaQ[15:8];
        sense[7] <= lbaQ[7:0];
      end
    end
  end

  for (genvar g = 0; g < WR_LEN; g++) begin : gModeByte
    always_ff @(posedge clk) begin
      if (!rstN) modeW[g] <= defaultModeByte(g);
      else if (stb.modeWrEn && idxAddr == 9'(g)) modeW[g] <= hostWrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ     <= ST_READY;
      errorQ      <= 8'h00;
      irqQ        <= 1'b0;
      lbaQ        <= 24'd0;
      modeQ       <= 8'h00;
      remainQ     <= 24'd0;
      lastOpQ     <= 8'h00;
      resetFlagQ  <= 1'b1;
      phaseStartQ <= 1'b0;
      phaseKindQ  <= PH_NONE;
      xferLenQ    <= 16'd0;
      winOffQ     <= 8'h00;
      srcQ        <= SRC_NONE;
    end else begin
      phaseStartQ <= stb.phaseGo;
      if (stb.report) errorQ <= {stb.code[3:0], 4'h0};
      unique case (stb.statOp)
        SO_FAIL:   statusQ <= ST_FAILED;
        SO_OK:     statusQ <= statusQ & ~(ST_BSY_BIT | ST_CHK_BIT);
        SO_OK_DRQ: statusQ <= (statusQ & ~(ST_BSY_BIT | ST_CHK_BIT)) | ST_DRQ_BIT;
        SO_BUSY:   statusQ <= (statusQ | ST_BSY_BIT) & ~ST_DRQ_BIT;
        SO_DONE:   statusQ <= statusQ & ~ST_DRQ_BIT;
        default:   statusQ <= statusQ;
      endcase
      if (stb.irqSet) irqQ <= 1'b1;
      else if (stb.irqClr || irqAck) irqQ <= 1'b0;
      if (stb.loadSector) begin
        lbaQ    <= stb.lba;
        remainQ <= stb.count;
        modeQ   <= stb.mode;
      end else if (stb.advance) begin
        lbaQ    <= lbaQ + 24'd1;
        remainQ <= remainQ - 24'd1;
      end
      if (stb.setLastOp) lastOpQ <= stb.lastOp;
      if (stb.clrResetFlag) resetFlagQ <= 1'b0;
      if (stb.phaseGo) begin
        phaseKindQ <= stb.phase;
        xferLenQ   <= stb.len;
        winOffQ    <= stb.winOff;
        srcQ       <= stb.src;
      end else if (stb.statOp == SO_DONE || stb.statOp == SO_BUSY || stb.statOp == SO_FAIL) begin
        phaseKindQ <= PH_NONE;
      end
    end
  end

  always_comb begin
    hostRdByte = 8'h00;
    unique case (srcQ)
      SRC_MODE: begin
        for (int i = 0; i < MODE_LEN; i++)
          if (idxAddr == 9'(i)) hostRdByte = (i < WR_LEN) ? modeW[i % WR_LEN] : defaultModeByte(i);
      end
      SRC_SENSE: begin
        for (int i = 0; i < SENSE_LEN; i++)
          if (idxAddr == 9'(i)) hostRdByte = sense[i];
      end
      SRC_STAT: begin
        unique case (idxAddr)
          9'd0:    hostRdByte = lbaQ[23:16];
          9'd1:    hostRdByte = lbaQ[15:8];
          9'd2:    hostRdByte = lbaQ[7:0];
          9'd3:    hostRdByte = modeQ;
          9'd4:    hostRdByte = remainQ[23:16];
          9'd5:    hostRdByte = remainQ[15:8];
          9'd6:    hostRdByte = remainQ[7:0];
          default: hostRdByte = 8'h00;
        endcase
      end
      default: hostRdByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/atapi_pkt_result.sv
module atapi_pkt_result
  import atapi_result_pkg::*;
#(
  parameter int MODE_LEN = 32,
  parameter int WR_LEN   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic [95:0] pktData,
  input  logic [7:0]  hostIdx,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrByte,
  output logic [7:0]  hostRdByte,
  input  logic        xferDone,
  input  logic        irqAck,
  output logic        sectorReq,
  output logic [23:0] sectorLba,
  output logic [7:0]  sectorMode,
  input  logic        sectorDone,
  input  logic        sectorOk,
  input  logic [15:0] sectorErr,
  input  logic [15:0] sectorBytes,
  output logic [7:0]  statusReg,
  output logic [7:0]  errorReg,
  output logic        irq,
  output logic        phaseStart,
  output logic [1:0]  phaseKind,
  output logic [15:0] xferLen
);
  ctrlStrobe_t stb;
  logic [23:0] remain;
  logic [7:0]  lastOp;
  logic        resetFlag;

  atapi_pkt_ctrl #(.MODE_LEN(MODE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktData(pktData),
    .xferDone(xferDone), .hostWrEn(hostWrEn), .sectorDone(sectorDone),
    .sectorOk(sectorOk), .sectorErr(sectorErr), .sectorBytes(sectorBytes),
    .resetFlag(resetFlag), .remain(remain), .lastOp(lastOp),
    .stb(stb), .sectorReq(sectorReq)
  );

  atapi_pkt_datapath #(.MODE_LEN(MODE_LEN), .WR_LEN(WR_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .irqAck(irqAck),
    .hostIdx(hostIdx), .hostWrByte(hostWrByte), .hostRdByte(hostRdByte),
    .lbaQ(sectorLba), .modeQ(sectorMode), .remainQ(remain), .lastOpQ(lastOp),
    .resetFlagQ(resetFlag), .statusQ(statusReg), .errorQ(errorReg), .irqQ(irq),
    .phaseStartQ(phaseStart), .phaseKindQ(phaseKind), .xferLenQ(xferLen)
  );
endmodule

// File: rtl/atapi_pkt_result_chk.sv
module atapi_pkt_result_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  statusReg,
  input logic        irq,
  input logic        sectorReq,
  input logic        sectorDone,
  input logic        sectorOk,
  input logic [23:0] sectorLba,
  input logic        phaseStart,
  input logic [1:0]  phaseKind
);
  assert_fail_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> irq);

  assert_fail_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> (!statusReg[7] && !statusReg[3] && phaseKind == 2'd0));

  assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    sectorReq |-> statusReg[7]);

  assert_lba_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sectorReq && sectorDone && sectorOk) |=> (sectorLba == $past(sectorLba) + 24'd1));

  assert_phase_drq_R12: assert property (@(posedge clk) disable iff (!rstN)
    phaseStart |-> (statusReg[3] && phaseKind != 2'd0 && irq));

  assert_phase_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    phaseStart |=> !phaseStart);
endmodule

bind atapi_pkt_result atapi_pkt_result_chk u_chk (
  .clk(clk), .rstN(rstN), .statusReg(statusReg), .irq(irq),
  .sectorReq(sectorReq), .sectorDone(sectorDone), .sectorOk(sectorOk),
  .sectorLba(sectorLba), .phaseStart(phaseStart), .phaseKind(phaseKind)
);

// File: tb/atapi_pkt_result_tb.sv
`timescale 1ns/1ps
module atapi_pkt_result_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [95:0] pktData = '0;
  logic [7:0]  hostIdx = 8'h00;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrByte = 8'h00;
  logic [7:0]  hostRdByte;
  logic        xferDone = 1'b0;
  logic        irqAck = 1'b0;
  logic        sectorReq;
  logic [23:0] sectorLba;
  logic [7:0]  sectorMode;
  logic        sectorDone = 1'b0;
  logic        sectorOk = 1'b0;
  logic [15:0] sectorErr = 16'h0000;
  logic [15:0] sectorBytes = 16'd0;
  logic [7:0]  statusReg, errorReg;
  logic        irq, phaseStart;
  logic [1:0]  phaseKind;
  logic [15:0] xferLen;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  atapi_pkt_result u_dut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktData(pktData),
    .hostIdx(hostIdx), .hostWrEn(hostWrEn), .hostWrByte(hostWrByte),
    .hostRdByte(hostRdByte), .xferDone(xferDone), .irqAck(irqAck),
    .sectorReq(sectorReq), .sectorLba(sectorLba), .sectorMode(sectorMode),
    .sectorDone(sectorDone), .sectorOk(sectorOk), .sectorErr(sectorErr),
    .sectorBytes(sectorBytes), .statusReg(statusReg), .errorReg(errorReg),
    .irq(irq), .phaseStart(phaseStart), .phaseKind(phaseKind), .xferLen(xferLen)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [95:0] mkPkt(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                                        input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b8,
                                        input logic [7:0] b9, input logic [7:0] b10);
    logic [95:0] p = '0;
    p[7:0] = op; p[15:8] = b1; p[23:16] = b2; p[31:24] = b3; p[39:32] = b4;
    p[71:64] = b8; p[79:72] = b9; p[87:80] = b10;
    return p;
  endfunction

  function automatic logic [7:0] modeDef(input int i);
    logic [7:0] b = 8'(i);
    return {b[3:0], ~b[3:0]};
  endfunction

  task automatic sendPkt(input logic [95:0] p);
    pktValid = 1'b1; pktData = p;
    tick();
    pktValid = 1'b0;
  endtask

  task automatic rdByte(input logic [7:0] idx, output logic [7:0] v);
    hostIdx = idx;
    #1;
    v = hostRdByte;
  endtask

  task automatic finishXfer();
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
  endtask

  task automatic mediaAnswer(input logic ok, input logic [15:0] err, input logic [15:0] nbytes);
    sectorDone = 1'b1; sectorOk = ok; sectorErr = err; sectorBytes = nbytes;
    tick();
    sectorDone = 1'b0;
  endtask

  task automatic testResetState();
    check("R1", "status", statusReg, 8'h50);
    check("R1", "error", errorReg, 8'h00);
    check("R1", "irq", irq, 1'b0);
    check("R1", "phaseKind", phaseKind, 2'd0);
    check("R1", "sectorReq", sectorReq, 1'b0);
  endtask

  task automatic testResetFlag();
    logic [7:0] v;
    sendPkt(mkPkt(8'h13, 0, 0, 0, 10, 0, 0, 0));
    check("R5", "sense served while flag set, status", statusReg, 8'h58);
    check("R2", "sense length", xferLen, 16'd10);
    rdByte(0, v); check("R1", "sense byte0 after reset", v, 8'h00);
    finishXfer();
    check("R12", "done status", statusReg, 8'h50);
    sendPkt(mkPkt(8'h00, 0, 0, 0, 0, 0, 0, 0));
    check("R5", "reset error status", statusReg, 8'h51);
    check("R3", "reset error reg", errorReg, 8'h60);
    check("R4", "irq on fail", irq, 1'b1);
    irqAck = 1'b1; tick(); irqAck = 1'b0;
    check("R4", "irq after ack", irq, 1'b0);
    sendPkt(mkPkt(8'h13, 0, 0, 0, 20, 0, 0, 0));
    check("R4", "success from fail clears check", statusReg, 8'h58);
    check("R2", "sense length clamp", xferLen, 16'd10);
    rdByte(0, v); check("R2", "sense byte0", v, 8'hF0);
    rdByte(2, v); check("R2", "sense byte2", v, 8'h06);
    rdByte(8, v); check("R2", "sense byte8", v, 8'h29);
    finishXfer();
    sendPkt(mkPkt(8'h00, 0, 0, 0, 0, 0, 0, 0));
    check("R5", "ready test after flag cleared", statusReg, 8'h50);
    check("R3", "error on success", errorReg, 8'h00);
    check("R5", "no phase for ready test", phaseKind, 2'd0);
  endtask

  task automatic testBadCmd();
    logic [7:0] v;
    sendPkt(mkPkt(8'h7E, 0, 0, 0, 0, 0, 0, 0));
    check("R11", "status", statusReg, 8'h51);
    check("R11", "error", errorReg, 8'h50);
    sendPkt(mkPkt(8'h13, 0, 0, 0, 10, 0, 0, 0));
    rdByte(2, v); check("R11", "sense byte2", v, 8'h05);
    rdByte(8, v); check("R11", "sense byte8", v, 8'h20);
    finishXfer();
    sendPkt(mkPkt(8'h00, 0, 0, 0, 0, 0, 0, 0));
    check("R4", "ready test clears only check", statusReg, 8'h50);
  endtask

  task automatic testModeWindow();
    logic [7:0] v;
    sendPkt(mkPkt(8'h11, 0, 8, 0, 4, 0, 0, 0));
    check("R12", "phaseStart", phaseStart, 1'b1);
    check("R12", "phaseKind in", phaseKind, 2'd1);
    check("R9", "mode len", xferLen, 16'd4);
    for (int k = 0; k < 4; k++) begin
      rdByte(8'(k), v); check("R10", "default mode byte", v, modeDef(8 + k));
    end
    tick();
    check("R12", "phaseStart one cycle", phaseStart, 1'b0);
    finishXfer();
    check("R12", "drq cleared", statusReg, 8'h50);
    sendPkt(mkPkt(8'h11, 0, 30, 0, 10, 0, 0, 0));
    check("R9", "clamped len", xferLen, 16'd2);
    rdByte(0, v); check("R9", "byte 30", v, modeDef(30));
    rdByte(1, v); check("R9", "byte 31", v, modeDef(31));
    finishXfer();
    sendPkt(mkPkt(8'h11, 0, 32, 0, 1, 0, 0, 0));
    check("R9", "offset at end fails", statusReg, 8'h51);
    check("R9", "bad field error", errorReg, 8'h50);
    check("R9", "no phase", phaseKind, 2'd0);
    sendPkt(mkPkt(8'h13, 0, 0, 0, 10, 0, 0, 0));
    rdByte(8, v); check("R9", "bad field sense byte8", v, 8'h24);
    finishXfer();
  endtask

  task automatic testModeSelect();
    logic [7:0] v;
    sendPkt(mkPkt(8'h12, 0, 8, 0, 4, 0, 0, 0));
    check("R10", "phaseKind out", phaseKind, 2'd2);
    check("R10", "out len", xferLen, 16'd4);
    for (int k = 0; k < 4; k++) begin
      hostIdx = 8'(k); hostWrByte = 8'hA0 + 8'(k); hostWrEn = 1'b1;
      tick();
      hostWrEn = 1'b0;
    end
    finishXfer();
    hostIdx = 0; hostWrByte = 8'hEE; hostWrEn = 1'b1;
    tick();
    hostWrEn = 1'b0;
    sendPkt(mkPkt(8'h11, 0, 8, 0, 4, 0, 0, 0));
    rdByte(0, v); check("R10", "byte 8 written, idle write ignored", v, 8'hA0);
    rdByte(1, v); check("R10", "byte 9 written", v, 8'hA1);
    rdByte(2, v); check("R10", "byte 10 protected", v, modeDef(10));
    rdByte(3, v); check("R10", "byte 11 protected", v, modeDef(11));
    finishXfer();
  endtask

  task automatic testSectorRun();
    sendPkt(mkPkt(8'h30, 8'h22, 8'h01, 8'h02, 8'hFF, 8'h00, 8'h00, 8'h02));
    check("R6", "busy", statusReg, 8'hD0);
    check("R6", "request", sectorReq, 1'b1);
    check("R6", "lba", sectorLba, 24'h0102FF);
    check("R6", "mode", sectorMode, 8'h22);
    mediaAnswer(1'b1, 16'h0, 16'd2048);
    check("R7", "status drq", statusReg, 8'h58);
    check("R7", "sector len", xferLen, 16'd2048);
    check("R7", "lba step", sectorLba, 24'h010300);
    check("R7", "request dropped", sectorReq, 1'b0);
    finishXfer();
    check("R7", "next request", sectorReq, 1'b1);
    check("R7", "busy again", statusReg, 8'hD0);
    mediaAnswer(1'b1, 16'h0, 16'd2048);
    check("R7", "lba step 2", sectorLba, 24'h010301);
    finishXfer();
    check("R7", "run done status", statusReg, 8'h50);
    check("R7", "no request", sectorReq, 1'b0);
    check("R7", "irq at end", irq, 1'b1);
    sendPkt(mkPkt(8'h30, 8'h01, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00));
    check("R6", "zero count success", statusReg, 8'h50);
    check("R6", "zero count no request", sectorReq, 1'b0);
  endtask

  task automatic testSectorFail();
    logic [7:0] v;
    sendPkt(mkPkt(8'h30, 8'h05, 8'h00, 8'hAB, 8'hCD, 8'h00, 8'h00, 8'h03));
    mediaAnswer(1'b1, 16'h0, 16'd512);
    finishXfer();
    mediaAnswer(1'b0, 16'h3102, 16'd0);
    check("R8", "fail status", statusReg, 8'h51);
    check("R8", "fail error", errorReg, 8'h20);
    check("R8", "lba unchanged", sectorLba, 24'h00ABCE);
    check("R8", "no request", sectorReq, 1'b0);
    sendPkt(mkPkt(8'h13, 0, 0, 0, 10, 0, 0, 0));
    rdByte(2, v); check("R8", "sense byte2", v, 8'h02);
    rdByte(5, v); check("R8", "sense byte5", v, 8'h00);
    rdByte(6, v); check("R8", "sense byte6", v, 8'hAB);
    rdByte(7, v); check("R8", "sense byte7", v, 8'hCE);
    rdByte(8, v); check("R8", "sense byte8", v, 8'h31);
    finishXfer();
    sendPkt(mkPkt(8'h10, 0, 0, 0, 10, 0, 0, 0));
    check("R9", "state len", xferLen, 16'd10);
    rdByte(1, v); check("R9", "state lba mid", v, 8'hAB);
    rdByte(2, v); check("R9", "state lba low", v, 8'hCE);
    rdByte(3, v); check("R9", "state mode", v, 8'h05);
    rdByte(6, v); check("R8", "remaining kept", v, 8'h02);
    finishXfer();
    sendPkt(mkPkt(8'h10, 0, 2, 0, 10, 0, 0, 0));
    check("R9", "state clamp", xferLen, 16'd8);
    rdByte(0, v); check("R9", "state offset", v, 8'hCE);
    finishXfer();
    sendPkt(mkPkt(8'h10, 0, 10, 0, 1, 0, 0, 0));
    check("R9", "state offset bad", statusReg, 8'h51);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    tick();
    testResetState();
    testResetFlag();
    testBadCmd();
    testModeWindow();
    testModeSelect();
    testSectorRun();
    testSectorFail();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule